// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block narrows an IEEE-754 binary32 operand to binary16 under one of three selectable rounding directions. It takes a 32-bit word and a 2-bit rounding select, and one clock edge later it presents the 16-bit result on a registered output. Infinities keep their sign. Every NaN becomes a single canonical quiet NaN. Results too large for binary16 go either to infinity or to the largest finite value. Results too small for binary16 go either to signed zero or to the smallest subnormal. Values that fall into the binary16 subnormal range are denormalised and rounded.

Rounding happens on the packed exponent-and-mantissa field. A carry out of the mantissa therefore moves the result into the next binade, or up to infinity, with no extra logic. Zeros and binary32 subnormals have no decoder of their own: they fall into the total-underflow path.

Top module: `f2h_narrow`

## Requirements
- R1: `dout` shows the conversion of the `din`/`rmode` pair sampled at the previous rising clock edge. A synchronous active-high `rst` clears `dout` to 0x0000.
- R2: Output bit 15 always equals input bit 31, whatever the input and the mode.
- R3: An input exponent field of 0xFF gives magnitude 0x7C00 when the mantissa is zero and magnitude 0x7E00 otherwise, with the input sign kept in both cases.
- R4: Overflow is when the input exponent field is 143 to 254. Nearest mode gives infinity (0x7C00 with sign). A directed mode gives infinity when it rounds away from zero for that sign, and 0x7BFF with sign otherwise.
- R5: Total underflow is when the input exponent field is 101 or below. The result is signed zero, except that a directed mode rounding away from zero gives magnitude 0x0001 whenever any of input bits 30..0 is set.
- R6: Input exponent fields 102 to 112 give a subnormal result. The output exponent field is zero, and the 24-bit significand with its hidden 1 is shifted right by 126 minus the input exponent field.
- R7: Input exponent fields 113 to 142 give a normal result. The output exponent field is the input exponent field minus 112, the output mantissa is input bits 22..13, and bits 12..0 are the discarded remainder.
- R8: Mode 2 (nearest) adds one when the discarded part is above half an output LSB. When it is exactly half, it adds one only if the kept LSB is 1 (ties to even).
- R9: Mode 0 rounds toward negative infinity and mode 1 toward positive infinity. A directed mode adds one to the magnitude only if it rounds away from zero for the sign and the discarded part is nonzero; otherwise it truncates.
- R10: The rounding increment carries through the 15-bit exponent-and-mantissa field. Mantissa 0x3FF moves to the next binade, the largest subnormal moves to 0x0400, and 0x7BFF moves to 0x7C00.
- R11: Mode 3 gives the same results as mode 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 32 | binary32 operand |
| rmode | input | 2 | Rounding select: 0 toward -inf, 1 toward +inf, 2 and 3 nearest-even |
| dout | output | 16 | Registered binary16 result |

## Verification
Hand-picked operands target each path:
- Exact ties with even and with odd kept bits separate ties-to-even from plain round-half-up.
- Values just below a binade edge and just below 65520 show whether the rounding carry reaches the exponent and infinity.
- Operands of both signs under each directed mode show whether the choice between infinity and the largest finite value, and between zero and the smallest subnormal, follows the sign.

Random operands then fill in the rest. Half of them are fully random words, which mostly exercise NaN, overflow and flush. The other half have exponents drawn from the window around the binary16 range, so that subnormal creation and both normal rounding directions are hit often. All of them are compared against a reference built on quantum arithmetic rather than on the field rebiasing that the RTL uses.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

    // Source format
    localparam int SGL_W    = 32;
    localparam int SGL_EW   = 8;
    localparam int SGL_MW   = 23;
    localparam int SGL_BIAS = 127;

    // Target format
    localparam int HLF_W    = 16;
    localparam int HLF_EW   = 5;
    localparam int HLF_MW   = 10;
    localparam int HLF_BIAS = 15;

    // Derived
    localparam int SIG_W      = SGL_MW + 1;
    localparam int SHIFT_W    = $clog2(SIG_W + 1);
    localparam int REB_W      = SGL_EW + 2;
    localparam int NORM_SHIFT = SGL_MW - HLF_MW;
    localparam int HLF_EMAX   = (1 << HLF_EW) - 1;
    localparam int BIAS_DIFF  = SGL_BIAS - HLF_BIAS;

    localparam logic [HLF_W-2:0] MAG_INF = (HLF_W-1)'(HLF_EMAX << HLF_MW);
    localparam logic [HLF_W-2:0] MAG_MAX = MAG_INF - 1'b1;
    localparam logic [HLF_W-2:0] MAG_NAN = MAG_INF | (HLF_W-1)'(1 << (HLF_MW - 1));

    typedef enum logic [1:0] {
        RM_DOWN     = 2'd0,
        RM_UP       = 2'd1,
        RM_NEAR     = 2'd2,
        RM_NEAR_ALT = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        K_NORMAL,
        K_SUBNORM,
        K_OVERFLOW,
        K_FLUSH,
        K_INF,
        K_NAN
    } kind_e;

    typedef struct packed {
        logic               sign;
        kind_e              kind;
        logic [HLF_EW-1:0]  exp_f;
        logic [SIG_W-1:0]   sig;
        logic [SHIFT_W-1:0] shift;
        logic               nonzero;
    } split_t;

    function automatic logic mode_nearest(input logic [1:0] m);
        return m[1];
    endfunction

    // Directed mode moving away from zero for the given sign
    function automatic logic rounds_away(input logic [1:0] m, input logic s);
        return !m[1] && (m[0] != s);
    endfunction

endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
    import f2h_pkg::*;
(
    input  logic [SGL_W-1:0] word,
    output split_t           split
);
    localparam logic signed [REB_W-1:0] REB_OVF = REB_W'(HLF_EMAX);
    localparam logic signed [REB_W-1:0] REB_UNF = -REB_W'(HLF_MW);

    logic [SGL_EW-1:0]        exp_raw;
    logic [SGL_MW-1:0]        man_raw;
    logic signed [REB_W-1:0]  reb;

    assign exp_raw = word[SGL_W-2 -: SGL_EW];
    assign man_raw = word[SGL_MW-1:0];
    assign reb     = $signed({{(REB_W-SGL_EW){1'b0}}, exp_raw}) - REB_W'(BIAS_DIFF);

    always_comb begin
        split.sign    = word[SGL_W-1];
        split.kind    = K_NORMAL;
        split.exp_f   = '0;
        split.sig     = {1'b0, man_raw};
        split.shift   = SHIFT_W'(NORM_SHIFT);
        split.nonzero = |word[SGL_W-2:0];
        if (&exp_raw) begin
            split.kind = (|man_raw) ? K_NAN : K_INF;
        end else if (reb >= REB_OVF) begin
            split.kind = K_OVERFLOW;
        end else if (reb < REB_UNF) begin
            split.kind = K_FLUSH;
        end else if (reb <= 0) begin
            split.kind  = K_SUBNORM;
            split.sig   = {1'b1, man_raw};
            split.shift = SHIFT_W'(NORM_SHIFT + 1) - reb[SHIFT_W-1:0];
        end else begin
            split.exp_f = reb[HLF_EW-1:0];
        end
    end
endmodule

// File: rtl/f2h_align.sv
module f2h_align
    import f2h_pkg::*;
(
    input  logic [SIG_W-1:0]   sig,
    input  logic [SHIFT_W-1:0] shift,
    output logic [HLF_MW-1:0]  kept,
    output logic [SIG_W-1:0]   rem
);
    localparam int WIDE_W = HLF_MW + SIG_W;

    logic [WIDE_W-1:0] wide;

    // The remainder keeps its MSB at the half-LSB weight for any shift
    assign wide = WIDE_W'({sig, {SIG_W{1'b0}}} >> shift);
    assign kept = wide[SIG_W +: HLF_MW];
    assign rem  = wide[SIG_W-1:0];
endmodule

// File: rtl/f2h_round.sv
module f2h_round
    import f2h_pkg::*;
(
    input  split_t            split,
    input  logic [HLF_MW-1:0] kept,
    input  logic [SIG_W-1:0]  rem,
    input  logic [1:0]        rmode,
    output logic [HLF_W-1:0]  result
);
    localparam logic [SIG_W-1:0] HALF = {1'b1, {(SIG_W-1){1'b0}}};

    logic              near;
    logic              away;
    logic              bump;
    logic [HLF_W-2:0]  field;
    logic [HLF_W-2:0]  mag;

    assign near = mode_nearest(rmode);
    assign away = rounds_away(rmode, split.sign);

    always_comb begin
        if (near) bump = (rem > HALF) || ((rem == HALF) && kept[0]);
        else      bump = away && (rem != '0);
    end

    // Carry runs into the exponent, reaching infinity when it must
    assign field = {split.exp_f, kept} + (HLF_W-1)'(bump);

    always_comb begin
        unique case (split.kind)
            K_INF:      mag = MAG_INF;
            K_NAN:      mag = MAG_NAN;
            K_OVERFLOW: mag = (near || away) ? MAG_INF : MAG_MAX;
            K_FLUSH:    mag = (!near && away && split.nonzero) ? (HLF_W-1)'(1) : '0;
            default:    mag = field;
        endcase
    end

    assign result = {split.sign, mag};
endmodule

// File: rtl/f2h_narrow.sv
module f2h_narrow
    import f2h_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SGL_W-1:0] din,
    input  logic [1:0]       rmode,
    output logic [HLF_W-1:0] dout
);
    split_t             split;
    logic [HLF_MW-1:0]  kept;
    logic [SIG_W-1:0]   rem;
    logic [HLF_W-1:0]   result;

    f2h_classify u_classify (
        .word  (din),
        .split (split)
    );

    f2h_align u_align (
        .sig   (split.sig),
        .shift (split.shift),
        .kept  (kept),
        .rem   (rem)
    );

    f2h_round u_round (
        .split  (split),
        .kept   (kept),
        .rem    (rem),
        .rmode  (rmode),
        .result (result)
    );

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= result;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (dout == '0));

    // R2
    sign_copy_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (dout[HLF_W-1] == $past(din[SGL_W-1])));

    // R3
    nan_canon_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (&$past(din[SGL_W-2 -: SGL_EW])) && (|$past(din[SGL_MW-1:0])))
        |-> (dout[HLF_W-2:0] == MAG_NAN));

    // R4
    ovf_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(din[SGL_W-2 -: SGL_EW]) >= 8'd143)
                     && ($past(din[SGL_W-2 -: SGL_EW]) != 8'hFF))
        |-> ((dout[HLF_W-2:0] == MAG_INF) || (dout[HLF_W-2:0] == MAG_MAX)));

    // R5
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(din[SGL_W-2 -: SGL_EW]) <= 8'd101))
        |-> (dout[HLF_W-2:0] <= 15'd1));
endmodule

// File: tb/sim_f2h_narrow.sv
`timescale 1ns/1ps
module sim_f2h_narrow;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] din = '0;
    logic [1:0]  rmode = '0;
    logic [15:0] dout;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    f2h_narrow u0 (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .rmode (rmode),
        .dout  (dout)
    );

    // Reference: quantise the exact value to the binary16 grid of its binade
    function automatic logic [15:0] ref_half(input logic [31:0] x, input logic [1:0] md);
        logic        sg;
        int          e, E, b, qe, s, p, code;
        longint      n, q, r, hv;
        logic        near, away, above, tie, rnz, inc;
        sg   = x[31];
        e    = int'(x[30:23]);
        near = md[1];
        away = (md == 2'd1 && !sg) || (md == 2'd0 && sg);
        if (e == 255) return {sg, (x[22:0] != 0) ? 15'h7E00 : 15'h7C00};
        if (x[30:0] == 0) return {sg, 15'h0000};
        n = (e == 0) ? longint'(x[22:0]) : longint'(x[22:0]) + (64'd1 << 23);
        E = ((e == 0) ? 1 : e) - 150;
        p = 0;
        for (int i = 0; i < 24; i++) if (n[i]) p = i;
        b = p + E;
        if (b > 15) return {sg, (near || away) ? 15'h7C00 : 15'h7BFF};
        qe = ((b < -14) ? -14 : b) - 10;
        s  = qe - E;
        if (s >= 40) begin
            q = 0; above = 1'b0; tie = 1'b0; rnz = 1'b1;
        end else begin
            q     = n >> s;
            r     = n & ((64'd1 << s) - 1);
            hv    = 64'd1 << (s - 1);
            above = r > hv;
            tie   = r == hv;
            rnz   = r != 0;
        end
        inc = near ? (above || (tie && q[0])) : (away && rnz);
        q   = q + inc;
        code = (qe + 24) * 1024 + int'(q);
        if (code >= 32'h7C00) return {sg, 15'h7C00};
        return {sg, code[14:0]};
    endfunction

    function automatic string tag_for(input logic [31:0] x, input logic [1:0] md);
        int e;
        e = int'(x[30:23]);
        if (e == 255) return "R3";
        if (e >= 143) return "R4";
        if (e <= 101) return "R5";
        if (e <= 112) return "R6";
        return md[1] ? "R8" : "R9";
    endfunction

    task automatic run(input logic [31:0] x, input logic [1:0] md,
                       input logic [15:0] exp_v, input string tag);
        din   = x;
        rmode = md;
        @(negedge clk);
        checks++;
        if (dout !== exp_v) begin
            fails++;
            $display("FAIL %s: din=%h mode=%0d got %h expected %h", tag, x, md, dout, exp_v);
        end
    endtask

    task automatic check_model(input logic [31:0] x, input logic [1:0] md, input string tag);
        run(x, md, ref_half(x, md), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] x;
        logic [1:0]  md;
        void'($urandom(32'd20240611));
        din = 32'h3F80_0000;
        repeat (3) @(negedge clk);
        checks++;
        if (dout !== 16'h0000) begin
            fails++;
            $display("FAIL R1: reset got %h expected 0000", dout);
        end
        rst = 1'b0;

        // R7 plain normal, R2 sign
        run(32'h3F80_0000, 2'd2, 16'h3C00, "R7");
        run(32'hBF80_0000, 2'd0, 16'hBC00, "R2");
        run(32'h477F_E000, 2'd2, 16'h7BFF, "R7");
        // R3 specials
        run(32'h7F80_0000, 2'd2, 16'h7C00, "R3");
        run(32'hFF80_0000, 2'd1, 16'hFC00, "R3");
        run(32'h7FC0_0001, 2'd0, 16'h7E00, "R3");
        run(32'hFF80_0001, 2'd2, 16'hFE00, "R3");
        // R4 overflow by direction
        run(32'h4974_2400, 2'd2, 16'h7C00, "R4");
        run(32'h4974_2400, 2'd0, 16'h7BFF, "R4");
        run(32'h4974_2400, 2'd1, 16'h7C00, "R4");
        run(32'hC974_2400, 2'd0, 16'hFC00, "R4");
        run(32'hC974_2400, 2'd1, 16'hFBFF, "R4");
        // R5 total underflow
        run(32'h0000_0001, 2'd1, 16'h0001, "R5");
        run(32'h0000_0001, 2'd0, 16'h0000, "R5");
        run(32'h8000_0001, 2'd0, 16'h8001, "R5");
        run(32'h8000_0001, 2'd2, 16'h8000, "R5");
        run(32'h0000_0000, 2'd1, 16'h0000, "R5");
        // R6 subnormal creation
        run(32'h3380_0000, 2'd2, 16'h0001, "R6");
        run(32'h3300_0000, 2'd2, 16'h0000, "R8");
        run(32'h3300_0000, 2'd1, 16'h0001, "R9");
        // R8 ties to even
        run(32'h3F80_1000, 2'd2, 16'h3C00, "R8");
        run(32'h3F80_3000, 2'd2, 16'h3C02, "R8");
        run(32'h3F80_1001, 2'd2, 16'h3C01, "R8");
        // R10 carries
        run(32'h3F7F_FFFF, 2'd2, 16'h3C00, "R10");
        run(32'h3F7F_FFFF, 2'd0, 16'h3BFF, "R9");
        run(32'h387F_F800, 2'd2, 16'h0400, "R10");
        run(32'h477F_F000, 2'd2, 16'h7C00, "R10");
        run(32'h477F_F000, 2'd0, 16'h7BFF, "R9");
        // R11 mode 3 as nearest
        run(32'h3F80_1800, 2'd3, 16'h3C01, "R11");
        run(32'h3F80_3000, 2'd3, 16'h3C02, "R11");

        // R1 reset mid-stream
        din = 32'h4000_0000;
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (dout !== 16'h0000) begin
            fails++;
            $display("FAIL R1: mid reset got %h expected 0000", dout);
        end
        rst = 1'b0;

        for (int k = 0; k < 4000; k++) begin
            x  = $urandom;
            md = 2'($urandom % 4);
            if (k % 2 == 1) x[30:23] = 8'($urandom_range(150, 95));
            if (k % 7 == 3) x[12:0] = 13'h1000;
            check_model(x, md, tag_for(x, md));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule